// File: doc/BRIEF.md
# Frame Buffer Fetch Sequencer

This block produces the stream of memory read requests that feeds a display controller with pixel data. It keeps a current and a next frame buffer base address and walks the frame at the current base. It goes line by line, and within each line burst by burst. Each burst is offered on a valid/ready request port. Each returned burst is reported back on a single completion strobe, so the block can limit how many requests are in flight.

There are four modes, selected by a 2-bit field. Modes 0 and 1 are single-shot: one frame is fetched, then the run flag drops and software must start the block again. Modes 2 and 3 stream: at every frame end the next-buffer address is promoted to current if software wrote it since the last promotion, and fetching restarts at once. Mode 3 can also split a progressive frame into two fields: the odd lines come first, then the even lines.

Back-pressure rules: a request is transferred on a clock edge where `req_valid` and `req_ready` are both high. Once raised, `req_valid` stays high with `req_addr` and `req_len` unchanged until that transfer happens. The only exception is dropping `cfg_master_en`, which withdraws the request. `cpl_valid` has no ready signal. The environment pulses it once per returned burst and never while no request is outstanding.

Top module: `fbfetch_seq`

## Requirements
- R1: While `cfg_master_en` is 0, `req_valid` stays 0. When it returns to 1, the fetch resumes at the request that was pending, with no request lost or repeated.
- R2: The requests of a frame with base B, line stride S bytes, N lines (N >= 1) and P bursts per line (P >= 1) are ordered line by line and then burst by burst. Line L, counted from 1, burst k, counted from 0, has address B + (L-1)*S + k*len*8, where len is `cfg_burst_len` in 8-byte beats. `req_len` equals `cfg_burst_len`.
- R3: In modes 0 and 1, `frame_done` is high in the cycle of the completion that empties the last burst of the frame. `run` is 0 from the next cycle, and no further request is offered until `run_set` is pulsed.
- R4: In modes 2 and 3, at a `frame_done` with the next-buffer address written since the last promotion, `cur_addr` takes that value on the following cycle. The next frame is fetched from it with no software action, and the written flag is cleared.
- R5: In modes 2 and 3, when the next-buffer address was not written during a frame, the following frame is fetched again from the same base.
- R6: In mode 3 with `cfg_interlace` = 1, lines 1, 3, 5, … are fetched first, then lines 2, 4, …. In every other mode, `cfg_interlace` has no effect on the request order.
- R7: The count of issued requests not yet completed never exceeds `cfg_max_out`. `req_valid` is 0 while the count equals the limit.
- R8: A request that is offered and not accepted stays offered with the same address and length in the next cycle, unless `cfg_master_en` drops.
- R9: A write of the next-buffer address in the same cycle as a promotion does not take part in that promotion. The written value is kept, flagged as written, and promoted at the following frame end.
- R10: `run_set` while `run` is 1 has no effect. A write of the current-buffer address while `run` is 1 is ignored. Reset clears `run`, `cur_addr`, `req_valid` and `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master_en | input | 1 | Allows requests to be issued |
| cfg_mode | input | 2 | 0,1 single-shot; 2,3 streaming; 3 allows interlace |
| cfg_interlace | input | 1 | Two-field odd/even order (mode 3 only) |
| cfg_stride | input | STRIDE_W | Bytes from one line start to the next |
| cfg_lines | input | LINE_W | Lines per frame (>= 1) |
| cfg_bpl | input | BPL_W | Bursts per line (>= 1) |
| cfg_burst_len | input | LEN_W | Beats per burst |
| cfg_max_out | input | OUT_W | Limit of outstanding requests (>= 1) |
| run_set | input | 1 | Pulse that starts fetching when idle |
| cur_wr | input | 1 | Write strobe for the current base |
| cur_wr_addr | input | ADDR_W | Current base write data |
| nxt_wr | input | 1 | Write strobe for the next base |
| nxt_wr_addr | input | ADDR_W | Next base write data |
| run | output | 1 | Run flag |
| cur_addr | output | ADDR_W | Current base address |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | LEN_W | Burst length in beats |
| cpl_valid | input | 1 | One burst of data returned |
| frame_done | output | 1 | Last completion of a frame |

## Verification
Two collisions matter most. The first is a software write of the next-buffer address in the very cycle a streaming frame ends. The bench detects the completion that will empty the frame and drives the write on that same edge. It then checks that the frame after it still uses the previously pending address and that the one after uses the colliding value. The second is a completion that returns in the same cycle a new request is accepted. The mostly-ready request port and the three-cycle completion rhythm provoke this many times. At every offered request, the bench compares the outstanding count it tracks from the port traffic against the limit.

// File: rtl/fbfetch_pkg.sv
package fbfetch_pkg;
  typedef enum logic [1:0] {
    FM_SINGLE_CMD  = 2'd0,
    FM_SINGLE_SYNC = 2'd1,
    FM_STREAM_PIX  = 2'd2,
    FM_STREAM_DIG  = 2'd3
  } fmode_e;

  function automatic logic mode_streams(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_allows_fields(input logic [1:0] m);
    return m == FM_STREAM_DIG;
  endfunction
endpackage

// File: rtl/fbfetch_bufreg.sv
module fbfetch_bufreg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cur_wr,
  input  logic [ADDR_W-1:0] cur_wr_addr,
  input  logic              nxt_wr,
  input  logic [ADDR_W-1:0] nxt_wr_addr,
  input  logic              swap,
  output logic [ADDR_W-1:0] cur_q,
  output logic [ADDR_W-1:0] nxt_q,
  output logic              nxt_pend,
  output logic [ADDR_W-1:0] load_base
);
  logic promote;
  assign promote   = swap && nxt_pend;
  assign load_base = promote ? nxt_q : cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      nxt_q    <= '0;
      nxt_pend <= 1'b0;
    end else begin
      if (cur_wr && !run) cur_q <= cur_wr_addr;
      else if (promote)   cur_q <= nxt_q;
      if (nxt_wr) nxt_q <= nxt_wr_addr;
      if (nxt_wr)    nxt_pend <= 1'b1;
      else if (swap) nxt_pend <= 1'b0;
    end
  end

  // R4: promotion copies the pending next base
  a_r4_swap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    swap && nxt_pend |=> cur_q == $past(nxt_q));
  // R5: no pending write keeps the base
  a_r5_swap_keep: assert property (@(posedge clk) disable iff (!rst_n)
    swap && !nxt_pend |=> $stable(cur_q));
  // R9: colliding write survives the promotion
  a_r9_late_write: assert property (@(posedge clk) disable iff (!rst_n)
    swap && nxt_wr |=> nxt_pend && nxt_q == $past(nxt_wr_addr));
  // R10: current base locked while running
  a_r10_cur_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run && !swap |=> $stable(cur_q));
endmodule

// File: rtl/fbfetch_walker.sv
module fbfetch_walker #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int LINE_W   = 11,
  parameter int BPL_W    = 8,
  parameter int LEN_W    = 5,
  parameter int BEAT_LG  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   load_base,
  input  logic                adv,
  input  logic                il_en,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [LINE_W-1:0]   cfg_lines,
  input  logic [BPL_W-1:0]    cfg_bpl,
  input  logic [LEN_W-1:0]    cfg_burst_len,
  output logic [ADDR_W-1:0]   addr,
  output logic                busy
);
  localparam int LW1 = LINE_W + 1;

  logic [LINE_W-1:0] line_q;
  logic              field_q;
  logic [BPL_W-1:0]  bidx_q;
  logic [ADDR_W-1:0] frm_base_q, line_base_q, boff_q;

  logic [LW1-1:0]    nxt_line;
  logic              line_over, to_field2, last_burst;
  logic [ADDR_W-1:0] stride_a, step_bytes, burst_bytes;

  assign stride_a    = ADDR_W'(cfg_stride);
  assign step_bytes  = il_en ? (stride_a << 1) : stride_a;
  assign burst_bytes = ADDR_W'(cfg_burst_len) << BEAT_LG;
  assign nxt_line    = {1'b0, line_q} + (il_en ? LW1'(2) : LW1'(1));
  assign line_over   = nxt_line > {1'b0, cfg_lines};
  assign to_field2   = il_en && !field_q && (cfg_lines >= LINE_W'(2));
  assign last_burst  = bidx_q == (cfg_bpl - BPL_W'(1));
  assign addr        = line_base_q + boff_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q      <= '0;
      field_q     <= 1'b0;
      bidx_q      <= '0;
      frm_base_q  <= '0;
      line_base_q <= '0;
      boff_q      <= '0;
      busy        <= 1'b0;
    end else if (load) begin
      frm_base_q  <= load_base;
      line_base_q <= load_base;
      line_q      <= LINE_W'(1);
      field_q     <= 1'b0;
      bidx_q      <= '0;
      boff_q      <= '0;
      busy        <= 1'b1;
    end else if (adv && busy) begin
      if (!last_burst) begin
        bidx_q <= bidx_q + BPL_W'(1);
        boff_q <= boff_q + burst_bytes;
      end else begin
        bidx_q <= '0;
        boff_q <= '0;
        if (!line_over) begin
          line_q      <= nxt_line[LINE_W-1:0];
          line_base_q <= line_base_q + step_bytes;
        end else if (to_field2) begin
          field_q     <= 1'b1;
          line_q      <= LINE_W'(2);
          line_base_q <= frm_base_q + stride_a;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end

  // R2: walked line stays inside the frame
  a_r2_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> line_q >= LINE_W'(1) && line_q <= cfg_lines);
  // R6: field 1 walks odd lines, field 2 even lines
  a_r6_field_parity: assert property (@(posedge clk) disable iff (!rst_n)
    busy && il_en |-> line_q[0] == !field_q);
endmodule

// File: rtl/fbfetch_credit.sv
module fbfetch_credit #(
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic [OUT_W-1:0] cfg_max_out,
  output logic             room,
  output logic             last_one
);
  logic [OUT_W-1:0] cnt_q;

  assign room     = cnt_q < cfg_max_out;
  assign last_one = cnt_q == OUT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + OUT_W'(inc) - OUT_W'(dec);
  end

  // R7: an issue never pushes the count past the limit
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> cnt_q < cfg_max_out);
  // R7: completions only arrive for outstanding bursts
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt_q != '0);
endmodule

// File: rtl/fbfetch_seq.sv
module fbfetch_seq
  import fbfetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int LINE_W     = 11,
  parameter int BPL_W      = 8,
  parameter int LEN_W      = 5,
  parameter int OUT_W      = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master_en,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_interlace,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [LINE_W-1:0]   cfg_lines,
  input  logic [BPL_W-1:0]    cfg_bpl,
  input  logic [LEN_W-1:0]    cfg_burst_len,
  input  logic [OUT_W-1:0]    cfg_max_out,
  input  logic                run_set,
  input  logic                cur_wr,
  input  logic [ADDR_W-1:0]   cur_wr_addr,
  input  logic                nxt_wr,
  input  logic [ADDR_W-1:0]   nxt_wr_addr,
  output logic                run,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [LEN_W-1:0]    req_len,
  input  logic                cpl_valid,
  output logic                frame_done
);
  localparam int BEAT_LG = $clog2(BEAT_BYTES);

  logic streaming, il_en, start, load, swap, issue;
  logic walk_busy, room, last_one;
  logic [ADDR_W-1:0] nxt_q, load_base;
  logic nxt_pend;

  assign streaming  = mode_streams(cfg_mode);
  assign il_en      = cfg_interlace && mode_allows_fields(cfg_mode);
  assign start      = run_set && !run;
  assign req_valid  = run && walk_busy && cfg_master_en && room;
  assign issue      = req_valid && req_ready;
  assign frame_done = run && !walk_busy && cpl_valid && last_one;
  assign swap       = frame_done && streaming;
  assign load       = start || swap;
  assign req_len    = cfg_burst_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                         run <= 1'b0;
    else if (start)                     run <= 1'b1;
    else if (frame_done && !streaming)  run <= 1'b0;
  end

  fbfetch_bufreg #(.ADDR_W(ADDR_W)) bufs_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cur_wr(cur_wr), .cur_wr_addr(cur_wr_addr),
    .nxt_wr(nxt_wr), .nxt_wr_addr(nxt_wr_addr),
    .swap(swap), .cur_q(cur_addr), .nxt_q(nxt_q),
    .nxt_pend(nxt_pend), .load_base(load_base)
  );

  fbfetch_walker #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LINE_W(LINE_W),
    .BPL_W(BPL_W), .LEN_W(LEN_W), .BEAT_LG(BEAT_LG)
  ) walk_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_base(load_base),
    .adv(issue), .il_en(il_en), .cfg_stride(cfg_stride),
    .cfg_lines(cfg_lines), .cfg_bpl(cfg_bpl),
    .cfg_burst_len(cfg_burst_len), .addr(req_addr), .busy(walk_busy)
  );

  fbfetch_credit #(.OUT_W(OUT_W)) credit_i (
    .clk(clk), .rst_n(rst_n), .inc(issue), .dec(cpl_valid),
    .cfg_max_out(cfg_max_out), .room(room), .last_one(last_one)
  );

  // R1: master enable gates every request
  a_r1_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master_en |-> !req_valid);
  // R3: single-shot frame end drops run and requests
  a_r3_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !streaming |=> !run && !req_valid);
  // R8: an unaccepted request is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !cfg_master_en || (req_valid && $stable(req_addr) && $stable(req_len)));
  // R4: streaming keeps running across frame end
  a_r4_keep_run: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> run);
endmodule

// File: tb/fbfetch_seq_tb_top.sv
module fbfetch_seq_tb_top;
  localparam int STRIDE = 'h100;
  localparam int BLEN   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master_en = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_interlace = 1'b0;
  logic [15:0] cfg_stride = 16'(STRIDE);
  logic [10:0] cfg_lines = 11'd1;
  logic [7:0]  cfg_bpl = 8'd1;
  logic [4:0]  cfg_burst_len = 5'(BLEN);
  logic [3:0]  cfg_max_out = 4'd1;
  logic run_set = 1'b0, cur_wr = 1'b0, nxt_wr = 1'b0;
  logic [31:0] cur_wr_addr = '0, nxt_wr_addr = '0;
  logic run, req_valid, frame_done;
  logic req_ready = 1'b0, cpl_valid = 1'b0;
  logic [31:0] cur_addr, req_addr;
  logic [4:0] req_len;

  fbfetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master_en(cfg_master_en), .cfg_mode(cfg_mode),
    .cfg_interlace(cfg_interlace), .cfg_stride(cfg_stride), .cfg_lines(cfg_lines),
    .cfg_bpl(cfg_bpl), .cfg_burst_len(cfg_burst_len), .cfg_max_out(cfg_max_out),
    .run_set(run_set), .cur_wr(cur_wr), .cur_wr_addr(cur_wr_addr),
    .nxt_wr(nxt_wr), .nxt_wr_addr(nxt_wr_addr), .run(run), .cur_addr(cur_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .cpl_valid(cpl_valid), .frame_done(frame_done)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, idx = 0, total = 1, bout = 0, frames = 0;
  int m_lines = 1, m_bpl = 1;
  bit m_il = 0, m_stream = 0, m_pend = 0;
  logic [31:0] m_cur = '0, m_nxt = '0;
  bit prev_hold = 0, chk_run_clr = 0, chk_cur = 0;
  logic [31:0] prev_addr = '0;
  bit want_nxt = 0, coll_arm = 0, done = 0;
  logic [31:0] want_val = '0, coll_val = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_exp(input logic [31:0] base, input int i);
    int k, b, ln, nodd;
    k = i / m_bpl;
    b = i % m_bpl;
    if (m_il) begin
      nodd = (m_lines + 1) / 2;
      ln = (k < nodd) ? 2 * k + 1 : 2 * (k - nodd) + 2;
    end else ln = k + 1;
    return base + 32'((ln - 1) * STRIDE + b * BLEN * 8);
  endfunction

  // memory side: drives ready, completions and next-base writes after each edge
  always @(posedge clk) begin
    #1;
    cyc++;
    req_ready = ((cyc * 7 + 3) % 5) != 0;
    cpl_valid = rst_n && (bout > 0) && ((cyc % 3) != 1);
    nxt_wr = 1'b0;
    if (coll_arm && cpl_valid && bout == 1 && idx == total) begin
      nxt_wr = 1'b1; nxt_wr_addr = coll_val; coll_arm = 0;   // R9 collision
    end else if (want_nxt) begin
      nxt_wr = 1'b1; nxt_wr_addr = want_val; want_nxt = 0;
    end
  end

  // observer: samples in the middle of the cycle
  always @(negedge clk) begin
    int idx_b, bout_b;
    bit hs, exp_fd;
    if (!rst_n) begin
      idx = 0; bout = 0; frames = 0; m_cur = '0; m_nxt = '0; m_pend = 0;
      prev_hold = 0; chk_run_clr = 0; chk_cur = 0;
    end else begin
      idx_b = idx; bout_b = bout;
      hs = req_valid && req_ready;
      if (!cfg_master_en && req_valid) chk(0, "R1 valid while disabled", 1, 0);
      if (req_valid) chk(bout_b < int'(cfg_max_out), "R7 outstanding", bout_b, cfg_max_out);
      if (prev_hold && req_valid) chk(req_addr == prev_addr, "R8 held address", req_addr, prev_addr);
      prev_hold = req_valid && !req_ready && cfg_master_en;
      prev_addr = req_addr;
      if (chk_run_clr) begin chk(run == 1'b0, "R3 run cleared", run, 0); chk_run_clr = 0; end
      if (chk_cur) begin chk(cur_addr == m_cur, "R4 cur_addr after frame end", cur_addr, m_cur); chk_cur = 0; end
      if (hs) begin
        if (idx < total) begin
          chk(req_addr == f_exp(m_cur, idx), "R2 request address", req_addr, f_exp(m_cur, idx));
          chk(req_len == 5'(BLEN), "R2 request length", req_len, BLEN);
        end else chk(0, "R3 request after frame end", req_addr, 0);
        idx++; bout++;
      end
      if (cpl_valid) bout--;
      exp_fd = cpl_valid && bout_b == 1 && idx_b == total && !hs;
      if (frame_done || exp_fd) chk(frame_done == exp_fd, "R3 frame_done", frame_done, exp_fd);
      if (frame_done) begin
        frames++;
        if (m_stream) begin
          if (m_pend) begin m_cur = m_nxt; m_pend = 0; end
          idx = 0; chk_cur = 1;
        end else chk_run_clr = 1;
      end
      if (nxt_wr) begin m_nxt = nxt_wr_addr; m_pend = 1; end
      if (cur_wr && !run) m_cur = cur_wr_addr;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    tick(1);
    rst_n = 0; run_set = 0; cur_wr = 0; cfg_master_en = 1;
    tick(3);
    rst_n = 1;
    tick(1);
  endtask

  task automatic set_cfg(input int mode, input bit il, input int lines, input int bpl, input int mo);
    cfg_mode = 2'(mode); cfg_interlace = il; cfg_lines = 11'(lines);
    cfg_bpl = 8'(bpl); cfg_max_out = 4'(mo);
    m_lines = lines; m_bpl = bpl; m_il = il && (mode == 3); m_stream = (mode >= 2);
    total = lines * bpl;
  endtask

  task automatic start_at(input logic [31:0] base);
    cur_wr = 1; cur_wr_addr = base;
    tick(1);
    cur_wr = 0; idx = 0; run_set = 1;
    tick(1);
    run_set = 0;
  endtask

  task automatic wait_frames(input int n, input string req);
    int lim = 0;
    while (frames < n && lim < 4000) begin tick(1); lim++; end
    if (frames < n) chk(0, req, frames, n);
  endtask

  initial begin
    int fbase;
    do_reset();
    @(negedge clk);
    chk(run == 0, "R10 reset run", run, 0);
    chk(req_valid == 0, "R10 reset req_valid", req_valid, 0);
    chk(frame_done == 0, "R10 reset frame_done", frame_done, 0);
    chk(cur_addr == 0, "R10 reset cur_addr", cur_addr, 0);

    // single-shot sweep (R2, R3, R7)
    for (int mode = 0; mode < 2; mode++)
      for (int ln = 1; ln <= 4; ln++)
        for (int bp = 1; bp <= 2; bp++)
          for (int mo = 1; mo <= 3; mo++) begin
            set_cfg(mode, 1'b1, ln, bp, mo);     // interlace ignored here (R6)
            fbase = frames;
            start_at(32'h1000_0000 + 32'(ln * 'h10000 + bp * 'h1000));
            if (ln == 4 && bp == 2 && mo == 1 && mode == 0) begin
              tick(3);
              run_set = 1; cur_wr = 1; cur_wr_addr = 32'hDEAD_0000;   // R10 ignored
              tick(1);
              run_set = 0; cur_wr = 0;
            end
            if (ln == 4 && bp == 2 && mo == 2 && mode == 1) begin
              tick(4);
              cfg_master_en = 0;                                     // R1 pause
              tick(12);
              cfg_master_en = 1;
            end
            wait_frames(fbase + 1, "R3 single-shot frame end");
            tick(10);
            chk(idx == total, "R3 no extra requests", idx, total);
            chk(cur_addr == m_cur, "R10 cur_addr unchanged", cur_addr, m_cur);
            chk(run == 0, "R3 idle after frame", run, 0);
          end

    // streaming sweep (R4, R5, R6, R9)
    for (int mode = 2; mode < 4; mode++)
      for (int il = 0; il < 2; il++)
        for (int ln = 1; ln <= 5; ln++) begin
          do_reset();
          set_cfg(mode, il[0], ln, 2, 2);
          start_at(32'h2000_0000);
          want_val = 32'h3000_0000; want_nxt = 1;       // promoted at frame 1 end (R4)
          wait_frames(2, "R4 frame 2");                 // frame 3 repeats base (R5)
          chk(cur_addr == 32'h3000_0000, "R5 base repeated", cur_addr, 32'h3000_0000);
          want_val = 32'h4000_0000; want_nxt = 1;
          while (want_nxt) tick(1);
          coll_val = 32'h5000_0000; coll_arm = 1;       // R9 lands on frame 3 end
          wait_frames(5, "R9 frames after collision");
          chk(cur_addr == 32'h5000_0000, "R9 late write promoted", cur_addr, 32'h5000_0000);
          chk(run == 1, "R4 still running", run, 1);
        end

    do_reset();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule